// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block lets a clocked system read and write a byte-wide asynchronous static RAM. A caller sees a simple request port. When `ready` is high, a one-clock `req` together with a direction bit, an address and write data starts one single-byte access. The sequencer then drives the memory's active-low select, output-enable and write-enable strobes from registers, so no strobe can glitch. It latches the read byte into `rdata` and raises `done` for one clock when the access is finished.

The memory data bus is split into an output value, a driver enable and an input value, so the pad cell stays outside the block. Every phase length is a count of system clocks. Each count is taken from a memory timing figure in picoseconds and the clock period, rounded up, and is never less than one. The byte to store is driven while output enable is held high, so the bus is never contested and the write pulse need not absorb the memory's driver turn-off time.

The states are:
- IDLE waits for a request, and a request moves it to RD_WAIT or WR_SET.
- RD_WAIT holds select and output enable low for the read access count. It then captures the bus and moves to RD_TURN.
- RD_TURN leaves the bus undriven for the turnaround count, then returns to IDLE.
- WR_SET selects the memory and drives data for the setup count, then moves to WR_STROBE.
- WR_STROBE holds write enable low for the pulse count, then moves to WR_HOLD.
- WR_HOLD keeps address and data for one clock, then returns to IDLE.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and after reset, with no request, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` and `done` are 0, and `ready` is 1.
- R2: One clock after a read request is accepted, `mem_cs_n` and `mem_oe_n` are 0, `mem_we_n` is 1, `mem_dq_oe` is 0 and `mem_addr` equals the request address. This holds for exactly RD_CYC clocks.
- R3: In the clock after the read strobes rise, `rdata` holds the value of `mem_dq_i` sampled on the last strobed clock and `done` is 1. `done` is never high two clocks in a row.
- R4: After a read, `ready` stays 0 for TURNAROUND clocks after `done` rises, then returns to 1 with `done` 0.
- R5: For WR_SETUP clocks after a write request is accepted, `mem_cs_n` is 0, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 1, `mem_dq_o` equals the write data and `mem_addr` equals the address.
- R6: `mem_we_n` is then 0 for exactly WR_PULSE clocks, with `mem_cs_n` 0, `mem_oe_n` 1 and data unchanged. `mem_we_n` is 0 only while `mem_cs_n` is 0 and `mem_oe_n` is 1.
- R7: For one clock after `mem_we_n` rises, address, data and `mem_dq_oe`=1 are held. On the next clock `mem_dq_oe` is 0, `done` is 1 and `ready` is 1.
- R8: A request while `ready` is 0 is ignored. `mem_addr` and the running sequence are unchanged, and `mem_addr` stays stable while `mem_cs_n` is low.
- R9: Each phase count is the ceiling of its timing figure over CLK_PS, and at least 1. The pulse uses the larger of the minimum pulse width and the data setup time. With the default figures at an 8000 ps clock, RD_CYC=2, WR_SETUP=1, WR_PULSE=1 and TURNAROUND=1.
- R10: `mem_dq_oe` is never 1 while `mem_oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, sampled when ready is 1 |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| ready | output | 1 | Sequencer idle, request will be taken |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DATA_W | Last byte read |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_o | output | DATA_W | Data to drive onto the bus |
| mem_dq_oe | output | 1 | Bus driver enable |
| mem_dq_i | input | DATA_W | Data seen on the bus |

## Verification
The bench builds the block with an 8-bit address so it can cover the whole address space. It first writes every one of the 256 locations with an arithmetic pattern, then reads them all back in reverse order. Both passes go through a behavioural memory that stores data only on the rising edge of write enable, so a wrong strobe length, wrong data or wrong address shows up as a wrong byte on the read pass. The reverse order separates address faults from data faults. Each access is also traced clock by clock against the phase counts, which the bench recomputes from the picosecond figures. One read is made while `req` is held high with a different address, to show that requests arriving mid-access are ignored.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_WAIT,
        S_RD_TURN,
        S_WR_SET,
        S_WR_STROBE,
        S_WR_HOLD
    } seq_state_t;

    // Clocks needed to cover a delay: rounded up, never below one.
    function automatic int clocks_for(input int delay_ps, input int clk_ps);
        int c;
        c = (delay_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_dq_o <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            mem_dq_o <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (capture) begin
            rdata <= mem_dq_i;
        end
    end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC     = 2,
    parameter int WR_SETUP   = 1,
    parameter int WR_PULSE   = 1,
    parameter int TURNAROUND = 1,
    parameter int CNT_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_wr,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             capture,
    output logic             ready,
    output logic             done,
    output logic             cs_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             dq_oe
);
    localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(TURNAROUND - 1);
    localparam logic [CNT_W-1:0] LD_SET  = CNT_W'(WR_SETUP - 1);
    localparam logic [CNT_W-1:0] LD_PUL  = CNT_W'(WR_PULSE - 1);

    seq_state_t st, nx;

    // next state
    always_comb begin
        nx = st;
        unique case (st)
            S_IDLE:      if (req) nx = req_wr ? S_WR_SET : S_RD_WAIT;
            S_RD_WAIT:   if (tmr_zero) nx = S_RD_TURN;
            S_RD_TURN:   if (tmr_zero) nx = S_IDLE;
            S_WR_SET:    if (tmr_zero) nx = S_WR_STROBE;
            S_WR_STROBE: if (tmr_zero) nx = S_WR_HOLD;
            S_WR_HOLD:   nx = S_IDLE;
            default:     nx = S_IDLE;
        endcase
    end

    always_comb begin
        tmr_load = (nx != st);
        unique case (nx)
            S_RD_WAIT:   tmr_val = LD_RD;
            S_RD_TURN:   tmr_val = LD_TURN;
            S_WR_SET:    tmr_val = LD_SET;
            S_WR_STROBE: tmr_val = LD_PUL;
            default:     tmr_val = '0;
        endcase
    end

    assign accept  = (st == S_IDLE) && req;
    assign capture = (st == S_RD_WAIT) && tmr_zero;
    assign ready   = (st == S_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nx;
    end

    // registered strobes, decoded from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n  <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            dq_oe <= 1'b0;
            done  <= 1'b0;
        end else begin
            cs_n  <= !(nx == S_RD_WAIT || nx == S_WR_SET || nx == S_WR_STROBE);
            oe_n  <= (nx != S_RD_WAIT);
            we_n  <= (nx != S_WR_STROBE);
            dq_oe <= (nx == S_WR_SET || nx == S_WR_STROBE || nx == S_WR_HOLD);
            done  <= (st == S_RD_WAIT && nx == S_RD_TURN) ||
                     (st == S_WR_HOLD && nx == S_IDLE);
        end
    end

    // strobe length trackers for the checks below
    logic [31:0] oe_low_len, we_low_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_low_len <= '0;
            we_low_len <= '0;
        end else begin
            oe_low_len <= oe_n ? '0 : oe_low_len + 1;
            we_low_len <= we_n ? '0 : we_low_len + 1;
        end
    end

    p_rd_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_n) |-> (oe_low_len == RD_CYC));

    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_we_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_low_len == WR_PULSE));

    p_we_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!cs_n && oe_n));

    p_hold_after_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> dq_oe);

    p_no_fight_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 8,
    parameter int CLK_PS  = 8000,
    parameter int T_RC_PS = 10000,
    parameter int T_AS_PS = 0,
    parameter int T_WP_PS = 7000,
    parameter int T_DW_PS = 5000,
    parameter int T_HZ_PS = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int RD_CYC     = clocks_for(T_RC_PS, CLK_PS);
    localparam int WR_SETUP   = clocks_for(T_AS_PS, CLK_PS);
    localparam int WR_PULSE   = clocks_for(max2(T_WP_PS, T_DW_PS), CLK_PS);
    localparam int TURNAROUND = clocks_for(T_HZ_PS, CLK_PS);
    localparam int MAX_CYC    = max2(max2(RD_CYC, WR_SETUP), max2(WR_PULSE, TURNAROUND));
    localparam int CNT_W      = $clog2(MAX_CYC + 1);

    logic             tmr_load, tmr_zero, accept, capture;
    logic [CNT_W-1:0] tmr_val;

    sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sram_seq_fsm #(
        .RD_CYC     (RD_CYC),
        .WR_SETUP   (WR_SETUP),
        .WR_PULSE   (WR_PULSE),
        .TURNAROUND (TURNAROUND),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_wr   (req_wr),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .accept   (accept),
        .capture  (capture),
        .ready    (ready),
        .done     (done),
        .cs_n     (mem_cs_n),
        .oe_n     (mem_oe_n),
        .we_n     (mem_we_n),
        .dq_oe    (mem_dq_oe)
    );

    sram_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_dq_i  (mem_dq_i),
        .mem_addr  (mem_addr),
        .mem_dq_o  (mem_dq_o),
        .rdata     (rdata)
    );

    p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    p_data_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o));

endmodule

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/1ps
module sim_sram_async_ctrl;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int CLKP = 8000;
    // phase counts recomputed from the timing figures (R9)
    localparam int RD_EXP   = ((10000 + CLKP - 1) / CLKP < 1) ? 1 : (10000 + CLKP - 1) / CLKP;
    localparam int SET_EXP  = ((0 + CLKP - 1) / CLKP < 1) ? 1 : (0 + CLKP - 1) / CLKP;
    localparam int PUL_EXP  = ((7000 + CLKP - 1) / CLKP < 1) ? 1 : (7000 + CLKP - 1) / CLKP;
    localparam int TURN_EXP = ((5000 + CLKP - 1) / CLKP < 1) ? 1 : (5000 + CLKP - 1) / CLKP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, req_wr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic ready, done, cs_n, oe_n, we_n, dq_oe;
    logic [DW-1:0] rdata, dq_o, dq_i;
    logic [AW-1:0] addr;

    int checks = 0, fails = 0, cyc = 0;
    bit ended = 0;

    always #4 clk = ~clk;

    sram_async_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PS(CLKP),
        .T_RC_PS(10000), .T_AS_PS(0), .T_WP_PS(7000), .T_DW_PS(5000), .T_HZ_PS(5000)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .ready(ready), .done(done), .rdata(rdata),
        .mem_addr(addr), .mem_cs_n(cs_n), .mem_oe_n(oe_n), .mem_we_n(we_n),
        .mem_dq_o(dq_o), .mem_dq_oe(dq_oe), .mem_dq_i(dq_i));

    // behavioural memory: stores on the rising edge of write enable
    logic [DW-1:0] model [0:(1<<AW)-1];
    logic p_we = 1'b1, p_cs = 1'b1, p_oe_d = 1'b0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_dq = '0;
    assign dq_i = (!cs_n && !oe_n && we_n) ? model[addr] : 8'h5A;

    always @(negedge clk) begin
        if (!p_we && we_n && !p_cs && p_oe_d) model[p_addr] = p_dq;
        p_we = we_n; p_cs = cs_n; p_addr = addr; p_dq = dq_o; p_oe_d = dq_oe;
    end

    function automatic logic [DW-1:0] pattern(input int a);
        return DW'((a * 37 + 11) ^ 8'h5C);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            summary();
        end
    end

    // called at a negedge with ready high; returns at the negedge done is seen
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        chk(ready == 1'b1, "R8 ready before write", ready, 1);
        req = 1'b1; req_wr = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0;
        for (int k = 0; k < SET_EXP; k++) begin
            chk(!cs_n && oe_n && we_n && dq_oe, "R5 R9 setup strobes",
                {cs_n, oe_n, we_n, dq_oe}, 4'b0111);
            chk(dq_o == d && addr == a, "R5 setup addr/data", {addr, dq_o}, {a, d});
            @(negedge clk);
        end
        for (int k = 0; k < PUL_EXP; k++) begin
            chk(!cs_n && oe_n && !we_n && dq_oe && dq_o == d, "R6 R9 write pulse",
                {cs_n, oe_n, we_n, dq_oe}, 4'b0101);
            @(negedge clk);
        end
        chk(we_n && dq_oe && dq_o == d && addr == a && !done, "R7 hold clock",
            {we_n, dq_oe, done}, 3'b110);
        @(negedge clk);
        chk(!dq_oe && done && ready, "R7 release and done", {dq_oe, done, ready}, 3'b011);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] e, input bit noisy);
        chk(ready == 1'b1, "R8 ready before read", ready, 1);
        req = 1'b1; req_wr = 1'b0; req_addr = a;
        @(negedge clk);
        if (noisy) begin req_wr = 1'b1; req_addr = ~a; end
        else req = 1'b0;
        for (int k = 0; k < RD_EXP; k++) begin
            chk(!cs_n && !oe_n && we_n && !dq_oe, "R2 R9 read strobes",
                {cs_n, oe_n, we_n, dq_oe}, 4'b0010);
            chk(addr == a, "R2 R8 read address", addr, a);
            @(negedge clk);
        end
        chk(cs_n && oe_n && done && !ready, "R3 strobes off with done",
            {cs_n, oe_n, done, ready}, 4'b1110);
        chk(rdata == e, "R3 read data", rdata, e);
        for (int k = 1; k < TURN_EXP; k++) begin
            @(negedge clk);
            chk(!ready, "R4 turnaround", ready, 0);
        end
        @(negedge clk);
        chk(ready && !done, "R4 ready after turnaround", {ready, done}, 2'b10);
        chk(addr == a, "R8 no new access", addr, a);
        req = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) model[i] = '0;
        repeat (3) @(negedge clk);
        chk(cs_n && oe_n && we_n && !dq_oe && !done, "R1 in reset",
            {cs_n, oe_n, we_n, dq_oe, done}, 5'b11100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n && oe_n && we_n && !dq_oe && !done && ready, "R1 after reset",
            {cs_n, oe_n, we_n, dq_oe, done, ready}, 6'b111001);
        chk(RD_EXP == 2 && SET_EXP == 1 && PUL_EXP == 1 && TURN_EXP == 1,
            "R9 derived counts", RD_EXP * 1000 + SET_EXP * 100 + PUL_EXP * 10 + TURN_EXP, 2111);
        for (int a = 0; a < (1 << AW); a++) do_write(AW'(a), pattern(a));
        for (int a = (1 << AW) - 1; a >= 0; a--) do_read(AW'(a), pattern(a), a == 77);
        do_write(8'h3C, 8'hC3);
        do_read(8'h3C, 8'hC3, 1'b1);
        repeat (2) @(negedge clk);
        chk(cs_n && oe_n && we_n && !dq_oe, "R8 idle without request",
            {cs_n, oe_n, we_n, dq_oe}, 4'b1110);
        summary();
    end

endmodule